// File: doc/BRIEF.md
# Compressed-to-Standard Instruction Expander

This block takes one 16-bit compressed RV32C instruction and rewrites it as the equivalent 32-bit RV32I word. The decoder downstream then only has to handle standard encodings. The block does not decode the compressed form into control signals. It reassembles a full instruction word. Bits [1:0] (the quadrant) and bits [15:13] (funct3) form a 5-bit slot number, and that slot picks the rewrite rule. Where several instructions share a slot, other fields tell them apart.

The result is either a legal 32-bit word or a raised illegal flag. All reserved encodings, the unused slots and quadrant 11 raise the flag. The output stage can be a register (one cycle of latency) or a plain wire, selected by a parameter. Fetch alignment, floating-point compressed forms and the 64/128-bit forms are the caller's concern.

Top module: `rvc_expander`

## Requirements
- R1: The slot is {in_half[1:0], in_half[15:13]}. Quadrant 11 (not compressed) and the unused slots are illegal. The unused slots are 00/001, 00/011, 00/100, 00/101, 00/111, 10/001, 10/011, 10/101 and 10/111.
- R2: A 3-bit register field r' names register 8+r'. rs1'/rd' sit at [9:7] in the arithmetic, branch, load and store forms. rd'/rs2' sit at [4:2].
- R3: Slot 00/000 becomes `addi rd', x2, uimm` with a zero-extended scaled immediate. The immediate bits are [10:7]=uimm[9:6], [12:11]=uimm[5:4], [5]=uimm[3] and [6]=uimm[2]. A zero immediate is illegal, and this includes the all-zero halfword. Slot 00/010 becomes `lw` and slot 00/110 becomes `sw`. Both use offset [5]=off[6], [12:10]=off[5:3] and [6]=off[2].
- R4: Slot 01/000 becomes `addi rd, rd, simm6` and slot 01/010 becomes `addi rd, x0, simm6`. simm6 is {[12],[6:2]}, sign-extended.
- R5: Slot 01/001 becomes `jal x1` and slot 01/101 becomes `jal x0`. The offset is sign-extended from [12] and uses [11]=off[4], [10:9]=off[9:8], [8]=off[10], [7]=off[6], [6]=off[7], [5:3]=off[3:1] and [2]=off[5].
- R6: In slot 01/011, rd=x2 selects `addi x2, x2, nzimm`. That immediate is sign-extended from [12]=imm[9] and uses [4:3]=imm[8:7], [5]=imm[6], [2]=imm[5] and [6]=imm[4]. Any other rd selects `lui rd, {[12],[6:2]}`, sign-extended. A zero immediate is illegal in both forms.
- R7: In slot 01/100, [11:10] chooses the operation: 00 srli, 01 srai, 10 andi with simm6, 11 the register group. In the register group, [6:5] chooses: 00 sub, 01 xor, 10 or, 11 and. Each writes rd' and reads rd'. A shift amount with [12] set is illegal, and so is the register group with [12] set.
- R8: Slot 01/110 becomes `beq rs1', x0` and slot 01/111 becomes `bne rs1', x0`. The offset is sign-extended from [12]=off[8] and uses [6:5]=off[7:6], [2]=off[5], [11:10]=off[4:3] and [4:3]=off[2:1].
- R9: Slot 10/000 becomes `slli rd, rd, shamt`, and [12] set is illegal. Slot 10/010 becomes `lw rd, off(x2)` with [12]=off[5], [6:4]=off[4:2] and [3:2]=off[7:6]; rd=x0 is illegal. Slot 10/110 becomes `sw rs2, off(x2)` with rs2=[6:2], [12:9]=off[5:2] and [8:7]=off[7:6].
- R10: Slot 10/100 is decoded from [12] and the fields at [11:7] and [6:2]:
  - [12]=0 and rs2=0 gives `jalr x0, 0(rs1)`. rs1=x0 is illegal.
  - [12]=0 and rs2≠0 gives `add rd, x0, rs2`.
  - [12]=1 with both fields zero gives `ebreak` (0x00100073).
  - [12]=1 and rs2=0 gives `jalr x1, 0(rs1)`.
  - Otherwise the result is `add rd, rd, rs2`.
- R11: When the input is valid and illegal, out_illegal=1 and out_word=0. When the input is not valid, out_valid=0, out_illegal=0 and out_word=0.
- R12: With REG_OUT=1, the outputs show the input of the previous clock edge. Reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | in_half carries an instruction |
| in_half | input | HALF_W (16) | Compressed instruction |
| out_valid | output | 1 | out_word / out_illegal are meaningful |
| out_word | output | WORD_W (32) | Expanded RV32I word, zero when illegal |
| out_illegal | output | 1 | Reserved or unsupported encoding |

## Verification
Directed halfwords are hand-assembled per slot and compared with hand-computed 32-bit words:
- Negative offsets separate correct sign extension from zero extension.
- rd=x2 against rd=x5 in slot 01/011 separates the stack adjust from the upper-immediate load.
- The five forms of slot 10/100 are told apart by rs1/rs2 zero patterns.

Each reserved case is applied next to a legal neighbour that differs in one field. This shows the illegal flag responds to that field alone. Thousands of random halfwords, with valid toggled, are compared with a bench model that builds each word from integer immediates. This covers scrambled immediate bit positions and the zeroing of invalid cycles.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

   localparam logic [6:0] OPC_LOAD   = 7'h03;
   localparam logic [6:0] OPC_OPIMM  = 7'h13;
   localparam logic [6:0] OPC_STORE  = 7'h23;
   localparam logic [6:0] OPC_OP     = 7'h33;
   localparam logic [6:0] OPC_LUI    = 7'h37;
   localparam logic [6:0] OPC_BRANCH = 7'h63;
   localparam logic [6:0] OPC_JALR   = 7'h67;
   localparam logic [6:0] OPC_JAL    = 7'h6F;
   localparam logic [6:0] OPC_SYSTEM = 7'h73;

   // slot = {quadrant, funct3}
   typedef enum logic [4:0] {
      SL_ADDI4SPN = 5'b00_000,
      SL_LW       = 5'b00_010,
      SL_SW       = 5'b00_110,
      SL_ADDI     = 5'b01_000,
      SL_JAL      = 5'b01_001,
      SL_LI       = 5'b01_010,
      SL_LUISP    = 5'b01_011,
      SL_ALU      = 5'b01_100,
      SL_J        = 5'b01_101,
      SL_BEQZ     = 5'b01_110,
      SL_BNEZ     = 5'b01_111,
      SL_SLLI     = 5'b10_000,
      SL_LWSP     = 5'b10_010,
      SL_CR       = 5'b10_100,
      SL_SWSP     = 5'b10_110
   } rvc_slot_e;

   typedef struct packed {
      logic [4:0]  rd;      // [11:7]
      logic [4:0]  rs2;     // [6:2]
      logic [4:0]  rp_hi;   // 8 + [9:7]
      logic [4:0]  rp_lo;   // 8 + [4:2]
      logic [11:0] simm6;
      logic [11:0] uimm_spn;
      logic [11:0] off_lsw;
      logic [11:0] off_lwsp;
      logic [11:0] off_swsp;
      logic [11:0] imm_sp16;
      logic [19:0] imm_lui;
      logic [20:0] off_jmp;
      logic [12:0] off_br;
   } rvc_fields_t;

   function automatic logic [31:0] mk_i(logic [11:0] imm, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
      return {imm, rs1, f3, rd, op};
   endfunction

   function automatic logic [31:0] mk_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
      return {f7, rs2, rs1, f3, rd, op};
   endfunction

   function automatic logic [31:0] mk_s(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                        logic [2:0] f3);
      return {imm[11:5], rs2, rs1, f3, imm[4:0], OPC_STORE};
   endfunction

   function automatic logic [31:0] mk_b(logic [12:0] imm, logic [4:0] rs1, logic [2:0] f3);
      return {imm[12], imm[10:5], 5'd0, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
   endfunction

   function automatic logic [31:0] mk_u(logic [19:0] imm, logic [4:0] rd);
      return {imm, rd, OPC_LUI};
   endfunction

   function automatic logic [31:0] mk_j(logic [20:0] imm, logic [4:0] rd);
      return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
   endfunction

endpackage

// File: rtl/rvc_field_unpack.sv
module rvc_field_unpack
   import rvc_pkg::*;
#(
   parameter int HALF_W = 16
) (
   input  logic [HALF_W-1:0] c,
   output rvc_fields_t       f
);

   localparam int SPREAD_W = HALF_W - 4;   // bits above the fixed field map

   always_comb begin
      f.rd       = c[11:7];
      f.rs2      = c[6:2];
      f.rp_hi    = {2'b01, c[9:7]};
      f.rp_lo    = {2'b01, c[4:2]};
      f.simm6    = {{6{c[12]}}, c[12], c[6:2]};
      f.uimm_spn = {2'b00, c[10:7], c[12:11], c[5], c[6], 2'b00};
      f.off_lsw  = {5'd0, c[5], c[12:10], c[6], 2'b00};
      f.off_lwsp = {4'd0, c[3:2], c[12], c[6:4], 2'b00};
      f.off_swsp = {4'd0, c[8:7], c[12:9], 2'b00};
      f.imm_sp16 = {{3{c[12]}}, c[4:3], c[5], c[2], c[6], 4'b0000};
      f.imm_lui  = {{14{c[12]}}, c[12], c[6:2]};
      f.off_jmp  = {{9{c[12]}}, c[12], c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
      f.off_br   = {{4{c[12]}}, c[12], c[6:5], c[2], c[11:10], c[4:3], 1'b0};
   end

   if (SPREAD_W != 12) begin : g_bad_width
      $error("rvc_field_unpack: HALF_W must be 16");
   end

endmodule

// File: rtl/rvc_expand_core.sv
module rvc_expand_core
   import rvc_pkg::*;
#(
   parameter int HALF_W = 16,
   parameter int WORD_W = 32
) (
   input  logic              valid_i,
   input  logic [HALF_W-1:0] c,
   input  rvc_fields_t       f,
   output logic [WORD_W-1:0] word_o,
   output logic              ill_o
);

   localparam int SLOT_W = 5;

   logic [SLOT_W-1:0] slot;
   logic [31:0]       word;
   logic              ill;

   assign slot = {c[1:0], c[15:13]};

   always_comb begin
      word = '0;
      ill  = 1'b0;
      case (slot)
         SL_ADDI4SPN: begin
            ill  = (f.uimm_spn == '0);
            word = mk_i(f.uimm_spn, 5'd2, 3'b000, f.rp_lo, OPC_OPIMM);
         end
         SL_LW:   word = mk_i(f.off_lsw, f.rp_hi, 3'b010, f.rp_lo, OPC_LOAD);
         SL_SW:   word = mk_s(f.off_lsw, f.rp_lo, f.rp_hi, 3'b010);
         SL_ADDI: word = mk_i(f.simm6, f.rd, 3'b000, f.rd, OPC_OPIMM);
         SL_JAL:  word = mk_j(f.off_jmp, 5'd1);
         SL_LI:   word = mk_i(f.simm6, 5'd0, 3'b000, f.rd, OPC_OPIMM);
         SL_LUISP: begin
            if (f.rd == 5'd2) begin
               ill  = (f.imm_sp16 == '0);
               word = mk_i(f.imm_sp16, 5'd2, 3'b000, 5'd2, OPC_OPIMM);
            end else begin
               ill  = (f.simm6 == '0);
               word = mk_u(f.imm_lui, f.rd);
            end
         end
         SL_ALU: begin
            case (c[11:10])
               2'b00: begin
                  ill  = c[12];
                  word = mk_i({7'b0000000, c[6:2]}, f.rp_hi, 3'b101, f.rp_hi, OPC_OPIMM);
               end
               2'b01: begin
                  ill  = c[12];
                  word = mk_i({7'b0100000, c[6:2]}, f.rp_hi, 3'b101, f.rp_hi, OPC_OPIMM);
               end
               2'b10: word = mk_i(f.simm6, f.rp_hi, 3'b111, f.rp_hi, OPC_OPIMM);
               default: begin
                  ill = c[12];
                  case (c[6:5])
                     2'b00:   word = mk_r(7'b0100000, f.rp_lo, f.rp_hi, 3'b000, f.rp_hi, OPC_OP);
                     2'b01:   word = mk_r(7'b0000000, f.rp_lo, f.rp_hi, 3'b100, f.rp_hi, OPC_OP);
                     2'b10:   word = mk_r(7'b0000000, f.rp_lo, f.rp_hi, 3'b110, f.rp_hi, OPC_OP);
                     default: word = mk_r(7'b0000000, f.rp_lo, f.rp_hi, 3'b111, f.rp_hi, OPC_OP);
                  endcase
               end
            endcase
         end
         SL_J:    word = mk_j(f.off_jmp, 5'd0);
         SL_BEQZ: word = mk_b(f.off_br, f.rp_hi, 3'b000);
         SL_BNEZ: word = mk_b(f.off_br, f.rp_hi, 3'b001);
         SL_SLLI: begin
            ill  = c[12];
            word = mk_i({7'b0000000, c[6:2]}, f.rd, 3'b001, f.rd, OPC_OPIMM);
         end
         SL_LWSP: begin
            ill  = (f.rd == 5'd0);
            word = mk_i(f.off_lwsp, 5'd2, 3'b010, f.rd, OPC_LOAD);
         end
         SL_CR: begin
            if (!c[12]) begin
               if (f.rs2 == 5'd0) begin
                  ill  = (f.rd == 5'd0);
                  word = mk_i(12'd0, f.rd, 3'b000, 5'd0, OPC_JALR);
               end else begin
                  word = mk_r(7'd0, f.rs2, 5'd0, 3'b000, f.rd, OPC_OP);
               end
            end else if (f.rs2 == 5'd0) begin
               if (f.rd == 5'd0) word = mk_i(12'd1, 5'd0, 3'b000, 5'd0, OPC_SYSTEM);
               else              word = mk_i(12'd0, f.rd, 3'b000, 5'd1, OPC_JALR);
            end else begin
               word = mk_r(7'd0, f.rs2, f.rd, 3'b000, f.rd, OPC_OP);
            end
         end
         SL_SWSP: word = mk_s(f.off_swsp, f.rs2, 5'd2, 3'b010);
         default: ill = 1'b1;
      endcase
   end

   assign ill_o  = valid_i & ill;
   assign word_o = (valid_i & ~ill) ? word[WORD_W-1:0] : '0;

   always_comb begin
      if (valid_i === 1'b1 && c[1:0] == 2'b11) begin
         assert_quadrant3_illegal_R1: assert (ill_o && word_o == '0);
      end
      if (valid_i === 1'b1 && !ill_o) begin
         assert_opcode_legal_R1: assert (word_o[6:0] inside {OPC_LOAD, OPC_OPIMM, OPC_STORE,
            OPC_OP, OPC_LUI, OPC_BRANCH, OPC_JALR, OPC_JAL, OPC_SYSTEM});
      end
      if (valid_i === 1'b1 && slot == SL_JAL) begin
         assert_jal_link_R5: assert (word_o[11:7] == 5'd1);
      end
   end

   if (WORD_W != 32) begin : g_bad_word
      $error("rvc_expand_core: WORD_W must be 32");
   end

endmodule

// File: rtl/rvc_out_stage.sv
module rvc_out_stage #(
   parameter int WORD_W  = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              ill_i,
   output logic              valid_o,
   output logic [WORD_W-1:0] word_o,
   output logic              ill_o
);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_o <= 1'b0;
            word_o  <= '0;
            ill_o   <= 1'b0;
         end else begin
            valid_o <= valid_i;
            word_o  <= word_i;
            ill_o   <= ill_i;
         end
      end

      assert_latency_on_R12: assert property (@(posedge clk) disable iff (!rst_n)
         valid_i |=> valid_o);
      assert_latency_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
         !valid_i |=> !valid_o);
   end else begin : g_comb
      assign valid_o = valid_i;
      assign word_o  = word_i;
      assign ill_o   = ill_i;
   end

endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
   import rvc_pkg::*;
#(
   parameter int HALF_W  = 16,
   parameter int WORD_W  = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [HALF_W-1:0] in_half,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_word,
   output logic              out_illegal
);

   localparam int RATIO = WORD_W / HALF_W;

   rvc_fields_t       fields;
   logic [WORD_W-1:0] core_word;
   logic              core_ill;

   if (HALF_W != 16 || RATIO != 2) begin : g_bad_params
      $error("rvc_expander: only HALF_W=16 and WORD_W=32 are defined");
   end

   rvc_field_unpack #(.HALF_W(HALF_W)) u_unpack (
      .c (in_half),
      .f (fields)
   );

   rvc_expand_core #(.HALF_W(HALF_W), .WORD_W(WORD_W)) u_core (
      .valid_i (in_valid),
      .c       (in_half),
      .f       (fields),
      .word_o  (core_word),
      .ill_o   (core_ill)
   );

   rvc_out_stage #(.WORD_W(WORD_W), .REG_OUT(REG_OUT)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (in_valid),
      .word_i  (core_word),
      .ill_i   (core_ill),
      .valid_o (out_valid),
      .word_o  (out_word),
      .ill_o   (out_illegal)
   );

   assert_illegal_zero_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> (out_valid && out_word == '0));
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_illegal && out_word == '0));

endmodule

// File: tb/rvc_expander_bench.sv
`timescale 1ns/1ps
module rvc_expander_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_half = '0;
   logic        out_valid;
   logic [31:0] out_word;
   logic        out_illegal;

   int n_vec = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   rvc_expander u_rvc_expander (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_half(in_half),
      .out_valid(out_valid), .out_word(out_word), .out_illegal(out_illegal)
   );

   // ---------------- bench reference model ----------------
   function automatic logic [31:0] bi(int imm, int rs1, int f3, int rd, int op);
      return {imm[11:0], rs1[4:0], f3[2:0], rd[4:0], op[6:0]};
   endfunction
   function automatic logic [31:0] br(int f7, int rs2, int rs1, int f3, int rd);
      return {f7[6:0], rs2[4:0], rs1[4:0], f3[2:0], rd[4:0], 7'h33};
   endfunction
   function automatic logic [31:0] bs(int imm, int rs2, int rs1);
      return {imm[11:5], rs2[4:0], rs1[4:0], 3'b010, imm[4:0], 7'h23};
   endfunction
   function automatic logic [31:0] bb(int imm, int rs1, int f3);
      return {imm[12], imm[10:5], 5'd0, rs1[4:0], f3[2:0], imm[4:1], imm[11], 7'h63};
   endfunction
   function automatic logic [31:0] bj(int imm, int rd);
      return {imm[20], imm[10:1], imm[11], imm[19:12], rd[4:0], 7'h6F};
   endfunction
   function automatic int sx(int v, int bits);
      int m = 1 << (bits - 1);
      return (v ^ m) - m;
   endfunction
   function automatic int bit_of(logic [15:0] c, int p);
      return int'(c[p]);
   endfunction

   // returns {illegal, word}
   function automatic logic [32:0] model(logic [15:0] c);
      int q   = int'(c[1:0]);
      int f3  = int'(c[15:13]);
      int rd  = int'(c[11:7]);
      int rs2 = int'(c[6:2]);
      int ph  = 8 + int'(c[9:7]);
      int pl  = 8 + int'(c[4:2]);
      int s6  = sx((bit_of(c, 12) << 5) | int'(c[6:2]), 6);
      int imm;
      if (q == 0 && f3 == 0) begin
         imm = (int'(c[10:7]) << 6) | (int'(c[12:11]) << 4) | (bit_of(c, 5) << 3) | (bit_of(c, 6) << 2);
         return (imm == 0) ? {1'b1, 32'd0} : {1'b0, bi(imm, 2, 0, pl, 'h13)};
      end
      if (q == 0 && (f3 == 2 || f3 == 6)) begin
         imm = (bit_of(c, 5) << 6) | (int'(c[12:10]) << 3) | (bit_of(c, 6) << 2);
         return (f3 == 2) ? {1'b0, bi(imm, ph, 2, pl, 'h03)} : {1'b0, bs(imm, pl, ph)};
      end
      if (q == 1) begin
         case (f3)
            0: return {1'b0, bi(s6, rd, 0, rd, 'h13)};
            2: return {1'b0, bi(s6, 0, 0, rd, 'h13)};
            1, 5: begin
               imm = (bit_of(c, 12) << 11) | (bit_of(c, 8) << 10) | (int'(c[10:9]) << 8) |
                     (bit_of(c, 6) << 7) | (bit_of(c, 7) << 6) | (bit_of(c, 2) << 5) |
                     (bit_of(c, 11) << 4) | (int'(c[5:3]) << 1);
               return {1'b0, bj(sx(imm, 12), (f3 == 1) ? 1 : 0)};
            end
            3: begin
               if (rd == 2) begin
                  imm = (bit_of(c, 12) << 9) | (int'(c[4:3]) << 7) | (bit_of(c, 5) << 6) |
                        (bit_of(c, 2) << 5) | (bit_of(c, 6) << 4);
                  return (imm == 0) ? {1'b1, 32'd0} : {1'b0, bi(sx(imm, 10), 2, 0, 2, 'h13)};
               end
               if (s6 == 0) return {1'b1, 32'd0};
               imm = s6;
               return {1'b0, imm[19:0], rd[4:0], 7'h37};
            end
            4: begin
               case (int'(c[11:10]))
                  0, 1: begin
                     if (c[12]) return {1'b1, 32'd0};
                     return {1'b0, bi(int'(c[6:2]) | ((c[10] ? 32 : 0) << 5), ph, 5, ph, 'h13)};
                  end
                  2: return {1'b0, bi(s6, ph, 7, ph, 'h13)};
                  default: begin
                     if (c[12]) return {1'b1, 32'd0};
                     case (int'(c[6:5]))
                        0: return {1'b0, br(32, pl, ph, 0, ph)};
                        1: return {1'b0, br(0, pl, ph, 4, ph)};
                        2: return {1'b0, br(0, pl, ph, 6, ph)};
                        default: return {1'b0, br(0, pl, ph, 7, ph)};
                     endcase
                  end
               endcase
            end
            default: begin
               imm = (bit_of(c, 12) << 8) | (int'(c[6:5]) << 6) | (bit_of(c, 2) << 5) |
                     (int'(c[11:10]) << 3) | (int'(c[4:3]) << 1);
               return {1'b0, bb(sx(imm, 9), ph, (f3 == 6) ? 0 : 1)};
            end
         endcase
      end
      if (q == 2) begin
         case (f3)
            0: return c[12] ? {1'b1, 32'd0} : {1'b0, bi(rs2, rd, 1, rd, 'h13)};
            2: begin
               imm = (int'(c[3:2]) << 6) | (bit_of(c, 12) << 5) | (int'(c[6:4]) << 2);
               return (rd == 0) ? {1'b1, 32'd0} : {1'b0, bi(imm, 2, 2, rd, 'h03)};
            end
            4: begin
               if (!c[12] && rs2 == 0) return (rd == 0) ? {1'b1, 32'd0} : {1'b0, bi(0, rd, 0, 0, 'h67)};
               if (!c[12])             return {1'b0, br(0, rs2, 0, 0, rd)};
               if (rs2 == 0 && rd == 0) return {1'b0, 32'h0010_0073};
               if (rs2 == 0)           return {1'b0, bi(0, rd, 0, 1, 'h67)};
               return {1'b0, br(0, rs2, rd, 0, rd)};
            end
            6: begin
               imm = (int'(c[8:7]) << 6) | (int'(c[12:9]) << 2);
               return {1'b0, bs(imm, rs2, 2)};
            end
            default: return {1'b1, 32'd0};
         endcase
      end
      return {1'b1, 32'd0};
   endfunction

   // ---------------- check helpers ----------------
   task automatic check(string req, logic ev, logic eill, logic [31:0] ew);
      n_vec++;
      if (out_valid !== ev || out_illegal !== eill || out_word !== ew) begin
         n_bad++;
         $display("FAIL %s: actual v=%0b ill=%0b word=%08h expected v=%0b ill=%0b word=%08h",
                  req, out_valid, out_illegal, out_word, ev, eill, ew);
      end
   endtask

   task automatic apply(logic v, logic [15:0] h);
      @(negedge clk);
      in_valid = v;
      in_half  = h;
      @(negedge clk);   // one register stage between
   endtask

   task automatic dir(string req, logic [15:0] h, logic eill, logic [31:0] ew);
      apply(1'b1, h);
      check(req, 1'b1, eill, ew);
   endtask

   initial begin : watchdog
      #1_000_000;
      n_bad++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      int seed;
      seed = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      check("R12 reset state", 1'b0, 1'b0, 32'd0);
      rst_n = 1'b1;

      dir("R3 addi4spn", 16'h0040, 1'b0, 32'h0041_0413);
      dir("R3 all-zero halfword", 16'h0000, 1'b1, 32'd0);
      dir("R3 addi4spn zero imm", 16'h001C, 1'b1, 32'd0);
      dir("R3 R2 c.lw", 16'h4044, 1'b0, 32'h0044_2483);
      dir("R4 c.nop", 16'h0001, 1'b0, 32'h0000_0013);
      dir("R4 c.li -1", 16'h557D, 1'b0, 32'hFFF0_0513);
      dir("R5 c.jal 0", 16'h2001, 1'b0, 32'h0000_00EF);
      dir("R5 c.j 0", 16'hA001, 1'b0, 32'h0000_006F);
      dir("R6 addi16sp -16", 16'h717D, 1'b0, 32'hFF01_0113);
      dir("R6 c.lui x5,1", 16'h6285, 1'b0, 32'h0000_12B7);
      dir("R6 c.lui zero imm", 16'h6081, 1'b1, 32'd0);
      dir("R7 c.srai", 16'h840D, 1'b0, 32'h4034_5413);
      dir("R7 c.srli shamt bit5", 16'h9001, 1'b1, 32'd0);
      dir("R7 R2 c.sub", 16'h8C05, 1'b0, 32'h4094_0433);
      dir("R8 c.beqz -2", 16'hDC7D, 1'b0, 32'hFE04_0FE3);
      dir("R9 c.slli shamt bit5", 16'h1042, 1'b1, 32'd0);
      dir("R9 c.lwsp rd=0", 16'h4002, 1'b1, 32'd0);
      dir("R9 c.swsp", 16'hC42E, 1'b0, 32'h00B1_2423);
      dir("R10 c.mv", 16'h852E, 1'b0, 32'h00B0_0533);
      dir("R10 c.add", 16'h952E, 1'b0, 32'h00B5_0533);
      dir("R10 c.jalr", 16'h9282, 1'b0, 32'h0002_80E7);
      dir("R10 c.ebreak", 16'h9002, 1'b0, 32'h0010_0073);
      dir("R10 c.jr rs1=0", 16'h8002, 1'b1, 32'd0);
      dir("R1 unused slot 00/001", 16'h2000, 1'b1, 32'd0);
      dir("R1 unused slot 10/111", 16'hE002, 1'b1, 32'd0);
      dir("R1 quadrant 11", 16'h0003, 1'b1, 32'd0);
      apply(1'b0, 16'h4044);
      check("R11 invalid input quiet", 1'b0, 1'b0, 32'd0);

      for (int i = 0; i < 4000; i++) begin
         logic [15:0] h;
         logic        v;
         logic [32:0] e;
         h = 16'($urandom);
         if (h[1:0] == 2'b11 && ($urandom % 4) != 0) h[1:0] = 2'($urandom % 3);
         v = ($urandom % 8) != 0;
         apply(v, h);
         e = model(h);
         if (v) check("R1..R11 random", 1'b1, e[32], e[31:0]);
         else   check("R11 random idle", 1'b0, 1'b0, 32'd0);
      end

      rst_n = 1'b0;
      #1;
      check("R12 async reset clears", 1'b0, 1'b0, 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule